// File: doc/BRIEF.md
# Scannable Cascaded Binary Up-Counter

This block is a 16-bit synchronous binary up-counter made of four identical 4-bit slices. Each slice counts when its own step enable is high. The lowest slice steps on the global count enable alone. Every higher slice steps only when the global enable is high and every slice below it holds all ones. Each slice reports a carry flag whenever its nibble reads 1111b.

For test, the sixteen flops can be linked into one serial shift chain. Bit 0 of the lowest slice takes the serial input. Bit 3 of each slice feeds bit 0 of the next slice up. Bit 15 leaves the block as the serial output. A 16-bit value is loaded by shifting it in most significant bit first, over sixteen clocks.

Reset is asynchronous and active low, and it overrides everything else. A scan shift takes priority over counting. A shift only happens while the count enable is also high.

Top module: `scan_cascade_counter`

## Requirements
- R1: While `rstN` is 0, `count` reads 0000h without waiting for a clock edge. This holds even when `cntEn` and `scanEn` are both 1.
- R2: On a rising `clk` edge with `cntEn`=1 and `scanEn`=0, `count` increases by exactly one.
- R3: On a rising edge with `cntEn`=0, `count` keeps its value, whatever `scanEn` and `scanIn` are.
- R4: `sliceCarry[k]` is 1 exactly when `count[4k+3:4k]` equals 1111b, for k = 0..3.
- R5: On a rising edge with `cntEn`=1 and `scanEn`=1, `count` becomes `{count[14:0], scanIn}`. All four slices shift together, whatever their carries. For example, 0002h with `scanIn`=1 becomes 0005h.
- R6: `scanOut` always equals `count[15]`. A value shifted in MSB-first over 16 clocks therefore appears in `count`.
- R7: A slice above the lowest steps only when all lower slices hold 1111b. For example, 00FFh steps to 0100h, 01FFh to 0200h, and 0FFFh to 1000h.
- R8: Stepping from FFFFh gives 0000h, and no flag stays set afterwards (all `sliceCarry` bits read 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cntEn | input | 1 | Global count enable; also required for scan shift |
| scanEn | input | 1 | Selects serial shift instead of counting |
| scanIn | input | 1 | Serial data into bit 0 |
| count | output | 16 | Counter state |
| sliceCarry | output | 4 | Per-slice all-ones flag |
| scanOut | output | 1 | Serial data out (bit 15) |

## Verification
All of the counter's state is visible on `count`. A wrong flop, a miswired carry gate or a broken scan link therefore shows up as a mismatch on the first clock after the faulty step. The cases that matter most are the carry boundaries, because in normal counting they would take thousands of clocks to reach. The bench reaches them quickly by loading values such as 00FFh and FFFEh through the scan chain. A reset applied in the middle of a cycle is checked before the next edge, which is what shows that the reset is asynchronous.

// File: rtl/scnt_pkg.sv
package scnt_pkg;
  localparam int SLICE_W = 4;
  localparam int SLICE_N = 4;
  localparam int CNT_W   = SLICE_W * SLICE_N;

  typedef struct packed {
    logic               shift;
    logic [SLICE_N-1:0] step;
  } ctrlStrobes_t;
endpackage

// File: rtl/scnt_ctrl.sv
module scnt_ctrl
  import scnt_pkg::*;
(
  input  logic               cntEn,
  input  logic               scanEn,
  input  logic [SLICE_N-2:0] lowCarry,
  output ctrlStrobes_t       strobes
);
  logic countMode;

  // shift requires the count enable too; shift wins over counting
  assign strobes.shift = cntEn & scanEn;
  assign countMode     = cntEn & ~scanEn;

  // slice 0 steps on the global enable alone
  assign strobes.step[0] = countMode;

  // higher slices use a wide AND over all lower carries
  for (genvar s = 1; s < SLICE_N; s++) begin : g_stepGate
    assign strobes.step[s] = countMode & (&lowCarry[s-1:0]);
  end
endmodule

// File: rtl/scnt_slice.sv
module scnt_slice #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         shift,
  input  logic         step,
  input  logic         serIn,
  output logic [W-1:0] q,
  output logic         carry,
  output logic         serOut
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      q <= '0;
    else if (shift) q <= {q[W-2:0], serIn};
    else if (step)  q <= q + 1'b1;
  end

  assign carry  = &q;
  assign serOut = q[W-1];
endmodule

// File: rtl/scnt_datapath.sv
module scnt_datapath
  import scnt_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic               scanIn,
  output logic [CNT_W-1:0]   count,
  output logic [SLICE_N-1:0] sliceCarry,
  output logic               scanOut
);
  logic [SLICE_N:0] chain;

  assign chain[0] = scanIn;

  for (genvar s = 0; s < SLICE_N; s++) begin : g_slice
    scnt_slice #(.W(SLICE_W)) slice_i (
      .clk    (clk),
      .rstN   (rstN),
      .shift  (strobes.shift),
      .step   (strobes.step[s]),
      .serIn  (chain[s]),
      .q      (count[s*SLICE_W +: SLICE_W]),
      .carry  (sliceCarry[s]),
      .serOut (chain[s+1])
    );
  end

  assign scanOut = chain[SLICE_N];
endmodule

// File: rtl/scan_cascade_counter.sv
module scan_cascade_counter
  import scnt_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cntEn,
  input  logic               scanEn,
  input  logic               scanIn,
  output logic [CNT_W-1:0]   count,
  output logic [SLICE_N-1:0] sliceCarry,
  output logic               scanOut
);
  ctrlStrobes_t strobes;

  scnt_ctrl ctrl_i (
    .cntEn    (cntEn),
    .scanEn   (scanEn),
    .lowCarry (sliceCarry[SLICE_N-2:0]),
    .strobes  (strobes)
  );

  scnt_datapath dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .scanIn     (scanIn),
    .count      (count),
    .sliceCarry (sliceCarry),
    .scanOut    (scanOut)
  );
endmodule

// File: rtl/scnt_checker.sv
module scnt_checker
  import scnt_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               cntEn,
  input logic               scanEn,
  input logic               scanIn,
  input logic [CNT_W-1:0]   count,
  input logic [SLICE_N-1:0] sliceCarry,
  input logic               scanOut
);
  AST_RESET_CLEAR: assert property (@(posedge clk) !rstN |-> count == '0); // R1
  AST_INCR_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (cntEn && !scanEn) |=> count == CNT_W'($past(count) + 1'b1)); // R2
  AST_HOLD_STATE: assert property (@(posedge clk) disable iff (!rstN)
    !cntEn |=> $stable(count)); // R3
  AST_SHIFT_CHAIN: assert property (@(posedge clk) disable iff (!rstN)
    (cntEn && scanEn) |=> count == {$past(count[CNT_W-2:0]), $past(scanIn)}); // R5
  AST_SER_OUT: assert property (@(posedge clk) disable iff (!rstN)
    scanOut == count[CNT_W-1]); // R6
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (cntEn && !scanEn && &count) |=> (count == '0 && sliceCarry == '0)); // R8
  for (genvar s = 0; s < SLICE_N; s++) begin : g_carryChk
    AST_SLICE_CARRY: assert property (@(posedge clk) disable iff (!rstN)
      sliceCarry[s] == (count[s*SLICE_W +: SLICE_W] == {SLICE_W{1'b1}})); // R4
  end
endmodule

bind scan_cascade_counter scnt_checker chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .cntEn      (cntEn),
  .scanEn     (scanEn),
  .scanIn     (scanIn),
  .count      (count),
  .sliceCarry (sliceCarry),
  .scanOut    (scanOut)
);

// File: tb/scan_cascade_counter_tb_top.sv
`timescale 1ns/1ps
module scan_cascade_counter_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic cntEn = 1'b0;
  logic scanEn = 1'b0;
  logic scanIn = 1'b0;
  logic [15:0] count;
  logic [3:0]  sliceCarry;
  logic        scanOut;

  int nChecks = 0;
  int nFails  = 0;
  int model   = 0;
  int cycles  = 0;

  always #2.5 clk = ~clk;

  scan_cascade_counter dut_i (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .scanEn(scanEn), .scanIn(scanIn),
    .count(count), .sliceCarry(sliceCarry), .scanOut(scanOut)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // compare every port against the behavioural model
  task automatic compareAll(input string tag);
    int expCarry = 0;
    for (int k = 0; k < 4; k++)
      if (((model >> (4*k)) & 15) == 15) expCarry = expCarry + (1 << k);
    check(tag, int'(count), model);
    check("R4 carry", int'(sliceCarry), expCarry);
    check("R6 scanOut", int'(scanOut), (model >> 15) & 1);
  endtask

  // one clock: drive at negedge, model update, sample 1ns after posedge
  task automatic clockOnce(input logic en, input logic sen, input logic sin);
    string tag;
    @(negedge clk);
    cntEn = en; scanEn = sen; scanIn = sin;
    @(posedge clk);
    #1;
    if (!en) tag = "R3 hold";
    else if (sen) begin
      tag = "R5 shift";
      model = (model * 2 + int'(sin)) % 65536;
    end else begin
      tag = "R2 incr";
      model = (model + 1) % 65536;
    end
    compareAll(tag);
  endtask

  task automatic scanLoad(input int value);
    for (int b = 15; b >= 0; b--) clockOnce(1'b1, 1'b1, logic'((value >> b) & 1));
    check("R6 loaded", int'(count), value);
  endtask

  task automatic asyncReset();
    @(negedge clk);
    cntEn = 1'b1; scanEn = 1'b1; scanIn = 1'b1;
    #0.7 rstN = 1'b0;
    #0.3;
    model = 0;
    check("R1 async clear", int'(count), 0);
    @(posedge clk);
    #1;
    check("R1 held in reset", int'(count), 0);
    @(negedge clk);
    rstN = 1'b1; cntEn = 1'b0; scanEn = 1'b0; scanIn = 1'b0;
  endtask

  initial begin : watchdog
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    nChecks++; nFails++;
    $display("FAIL watchdog actual=%0d expected<20000", cycles);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    #1 rstN = 1'b0;
    #0.5;
    check("R1 reset state", int'(count), 0);
    @(negedge clk);
    rstN = 1'b1;
    compareAll("R1 after release");

    for (int i = 0; i < 20; i++) clockOnce(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++)  clockOnce(1'b0, 1'b0, 1'b0);
    clockOnce(1'b0, 1'b1, 1'b1);   // scan without enable: hold (R3)

    // 0002h shifted with 1 -> 0005h (R5)
    asyncReset();
    clockOnce(1'b1, 1'b0, 1'b0);
    clockOnce(1'b1, 1'b0, 1'b0);
    clockOnce(1'b1, 1'b1, 1'b1);
    check("R5 example", int'(count), 16'h0005);

    scanLoad(16'h00FF);
    clockOnce(1'b0, 1'b0, 1'b0);
    clockOnce(1'b1, 1'b0, 1'b0);
    check("R7 00FF step", int'(count), 16'h0100);

    scanLoad(16'h01FF);
    clockOnce(1'b1, 1'b0, 1'b0);
    check("R7 01FF step", int'(count), 16'h0200);

    scanLoad(16'h0FFF);
    clockOnce(1'b1, 1'b0, 1'b0);
    check("R7 0FFF step", int'(count), 16'h1000);

    scanLoad(16'hF0FF);
    clockOnce(1'b1, 1'b0, 1'b0);
    check("R7 no skip", int'(count), 16'hF100);

    scanLoad(16'hFFFE);
    clockOnce(1'b1, 1'b0, 1'b0);
    check("R4 all carries", int'(sliceCarry), 4'hF);
    clockOnce(1'b1, 1'b0, 1'b0);
    check("R8 wrap", int'(count), 0);
    check("R8 no flag", int'(sliceCarry), 0);

    // shift while carries are active: all slices still shift (R5)
    scanLoad(16'hA5FF);
    clockOnce(1'b1, 1'b1, 1'b0);
    check("R5 shift over carries", int'(count), 16'h4BFE);

    for (int i = 0; i < 5; i++) clockOnce(1'b1, 1'b1, 1'b1);
    asyncReset();
    compareAll("R1 after mid-scan reset");
    clockOnce(1'b1, 1'b0, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule